// File: doc/BRIEF.md
# Parameter Block Checksum Sequencer

This block walks a region of a byte-wide parameter memory, computes a 16-bit checksum over it and writes that checksum back into the same memory. A single-cycle start pulse supplies three values: where the region begins, how many bytes it holds, and where the result goes. The block then drives a plain synchronous memory port. Each read returns its data one cycle after the request.

Bytes are taken two at a time. The byte at the lower address forms the upper half of each 16-bit word. Each word is folded into a running value with a fixed nibble-and-XOR update. If the byte count is odd, the last byte forms the upper half of a final word whose lower half is zero. When all words are folded, the upper result byte is written at the store address and the lower byte at the next address. A one-cycle done pulse follows. A typical setup sums 0xF8 bytes from address 0x00 and places the result at 0xFC.

Top module: `nck_engine`

## Requirements
- R1: The running checksum starts each job at 0xFFFF. A job with a byte count of zero writes 0xFF and then 0xFF.
- R2: Each word is built from two bytes. The byte at the lower address is bits 15:8, and the byte at the next address is bits 7:0.
- R3: Let d = old XOR word, a = d[3:0] and b = d[7:4] XOR a. The new checksum is the lower 16 bits of (old >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12).
- R4: When the byte count is odd, the last byte is folded as the word {byte, 0x00}.
- R5: Word pairs do not overlap. The read pointer advances by two per word, and reads cover exactly the requested byte count in rising address order.
- R6: Reads have one cycle of latency. A word takes three cycles: read of the upper byte, read of the lower byte, then the fold. The first read is issued in the cycle after start is sampled. A trailing odd byte takes one read cycle and one fold cycle.
- R7: The result is written in two consecutive cycles. The upper byte goes to the store address and the lower byte to the store address plus one. Read and write strobes are never active together.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the lower result byte is written.
- R9: `busy_o` is low after reset. It rises in the cycle after an accepted start and stays high up to and including the done cycle. A start pulse while `busy_o` is high, including during the done cycle, has no effect.
- R10: Read and store addresses wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, sampled only when idle |
| start_addr_i | input | AW | First byte address of the region |
| count_i | input | AW+1 | Number of bytes in the region |
| store_addr_i | input | AW | Address for the upper result byte |
| mem_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Read strobe; data is returned the next cycle |
| mem_rdata_i | input | 8 | Read data |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the done cycle itself. Here `busy_o` is still high but the sequencer is one edge away from idle. The stimulus waits until the done pulse has been observed, then raises start for exactly the next edge, and expects the port to stay idle afterwards. Address wrap is reached with a region that starts three bytes below the top of memory and a store address of 0xFF.

// File: rtl/nck_pkg.sv
package nck_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned SUM_W  = 16;

   typedef enum logic [3:0] {
      S_IDLE, S_RD_HI, S_RD_LO, S_FOLD, S_RD_ODD,
      S_FOLD_ODD, S_WR_HI, S_WR_LO, S_DONE
   } nck_state_e;

   function automatic logic [SUM_W-1:0] nck_step(input logic [SUM_W-1:0] prev,
                                                  input logic [SUM_W-1:0] word);
      logic [SUM_W-1:0] d, a, b;
      d = prev ^ word;
      a = {12'h000, d[3:0]};
      b = {12'h000, d[7:4] ^ d[3:0]};
      return (prev >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
   endfunction
endpackage

// File: rtl/nck_accum.sv
module nck_accum
   import nck_pkg::*;
#(
   parameter logic [SUM_W-1:0] SEED = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_i,
   input  logic             fold_i,
   input  logic [SUM_W-1:0] word_i,
   output logic [SUM_W-1:0] sum_o
);
   logic [SUM_W-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q <= SEED;
      else if (seed_i) sum_q <= SEED;
      else if (fold_i) sum_q <= nck_step(sum_q, word_i);
   end

   assign sum_o = sum_q;
endmodule

// File: rtl/nck_span.sv
module nck_span #(
   parameter int unsigned AW = 8,
   parameter int unsigned CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] base_i,
   input  logic [CW-1:0] len_i,
   input  logic          adv_i,
   output logic [AW-1:0] ptr_o,
   output logic [CW-1:0] rem_o,
   output logic [CW-1:0] rem_after_o
);
   localparam logic [AW-1:0] PAIR_A = AW'(2);
   localparam logic [CW-1:0] PAIR_C = CW'(2);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("nck_span: AW must be at least 2");
      end
      if (CW <= AW) begin : g_bad_cw
         $error("nck_span: CW must exceed AW to cover a full memory");
      end
   endgenerate

   logic [AW-1:0] ptr_q;
   logic [CW-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         rem_q <= '0;
      end else if (load_i) begin
         ptr_q <= base_i;
         rem_q <= len_i;
      end else if (adv_i) begin
         ptr_q <= ptr_q + PAIR_A;
         rem_q <= rem_q - PAIR_C;
      end
   end

   assign ptr_o       = ptr_q;
   assign rem_o       = rem_q;
   assign rem_after_o = rem_q - PAIR_C;
endmodule

// File: rtl/nck_engine.sv
module nck_engine
   import nck_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter logic [15:0] SEED = 16'hFFFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [AW-1:0]        start_addr_i,
   input  logic [AW:0]          count_i,
   input  logic [AW-1:0]        store_addr_i,
   output logic [AW-1:0]        mem_addr_o,
   output logic                 mem_rd_o,
   input  logic [BYTE_W-1:0]    mem_rdata_i,
   output logic                 mem_wr_o,
   output logic [BYTE_W-1:0]    mem_wdata_o,
   output logic                 busy_o,
   output logic                 done_o
);
   localparam int unsigned CW = AW + 1;
   localparam logic [AW-1:0] ONE_A = AW'(1);

   generate
      if (SUM_W != 2 * BYTE_W) begin : g_bad_w
         $error("nck_engine: checksum must be two bytes wide");
      end
   endgenerate

   nck_state_e state_q, state_d;
   logic [BYTE_W-1:0] hi_q;
   logic [AW-1:0]     store_q;
   logic [AW-1:0]     ptr;
   logic [CW-1:0]     rem, rem_after;
   logic [SUM_W-1:0]  sum, word;
   logic              accept, fold_en;

   function automatic nck_state_e route(input logic [CW-1:0] left);
      if (left >= CW'(2))      return S_RD_HI;
      else if (left == CW'(1)) return S_RD_ODD;
      else                     return S_WR_HI;
   endfunction

   assign accept  = (state_q == S_IDLE) && start_i;
   assign fold_en = (state_q == S_FOLD) || (state_q == S_FOLD_ODD);
   assign word    = (state_q == S_FOLD_ODD) ? {mem_rdata_i, 8'h00}
                                            : {hi_q, mem_rdata_i};

   nck_span #(.AW(AW), .CW(CW)) u_span (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (accept),
      .base_i      (start_addr_i),
      .len_i       (count_i),
      .adv_i       (state_q == S_FOLD),
      .ptr_o       (ptr),
      .rem_o       (rem),
      .rem_after_o (rem_after)
   );

   nck_accum #(.SEED(SEED)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .seed_i (accept),
      .fold_i (fold_en),
      .word_i (word),
      .sum_o  (sum)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:     if (start_i) state_d = route(count_i);
         S_RD_HI:    state_d = S_RD_LO;
         S_RD_LO:    state_d = S_FOLD;
         S_FOLD:     state_d = route(rem_after);
         S_RD_ODD:   state_d = S_FOLD_ODD;
         S_FOLD_ODD: state_d = S_WR_HI;
         S_WR_HI:    state_d = S_WR_LO;
         S_WR_LO:    state_d = S_DONE;
         S_DONE:     state_d = S_IDLE;
         default:    state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         hi_q    <= '0;
         store_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept)               store_q <= store_addr_i;
         if (state_q == S_RD_LO)   hi_q    <= mem_rdata_i;
      end
   end

   always_comb begin
      unique case (state_q)
         S_RD_LO: mem_addr_o = ptr + ONE_A;
         S_WR_HI: mem_addr_o = store_q;
         S_WR_LO: mem_addr_o = store_q + ONE_A;
         default: mem_addr_o = ptr;
      endcase
   end

   assign mem_rd_o    = (state_q == S_RD_HI) || (state_q == S_RD_LO) || (state_q == S_RD_ODD);
   assign mem_wr_o    = (state_q == S_WR_HI) || (state_q == S_WR_LO);
   assign mem_wdata_o = (state_q == S_WR_HI) ? sum[15:8] : sum[7:0];
   assign busy_o      = (state_q != S_IDLE);
   assign done_o      = (state_q == S_DONE);

   logic unused_rem;
   assign unused_rem = ^rem;
endmodule

// File: rtl/nck_engine_chk.sv
module nck_engine_chk #(
   parameter int unsigned AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          mem_rd_o,
   input logic          mem_wr_o,
   input logic [AW-1:0] mem_addr_o
);
   p_rw_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));

   p_access_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o || mem_wr_o) |-> busy_o);

   p_busy_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(mem_wr_o) && !mem_wr_o));

   p_write_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && !$past(mem_wr_o)) |=> (mem_wr_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

   p_read_adjacent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));
endmodule

bind nck_engine nck_engine_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .mem_rd_o   (mem_rd_o),
   .mem_wr_o   (mem_wr_o),
   .mem_addr_o (mem_addr_o)
);

// File: tb/nck_engine_test.sv
`timescale 1ns/1ps
module nck_engine_test;
   localparam int AW = 8;
   localparam int MSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic [AW:0]   count_i = '0;
   logic [AW-1:0] store_addr_i = '0;
   logic [AW-1:0] mem_addr_o;
   logic          mem_rd_o, mem_wr_o, busy_o, done_o;
   logic [7:0]    mem_rdata_i;
   logic [7:0]    mem_wdata_o;

   always #10 clk = ~clk;

   nck_engine #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .count_i(count_i), .store_addr_i(store_addr_i), .mem_addr_o(mem_addr_o),
      .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i), .mem_wr_o(mem_wr_o),
      .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .done_o(done_o)
   );

   logic [7:0] mem [0:MSZ-1];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MSZ; i++) mem[i] <= 8'((i * 37 + 11) ^ (i >> 3));
         mem_rdata_i <= 8'h00;
      end else begin
         if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
         if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
      end
   end

   typedef struct {
      bit bsy; bit rd; bit wr; int addr; int wdata; bit done;
   } step_t;
   step_t q[$];
   int total = 0;
   int bad = 0;

   // R3 update, written with integer arithmetic
   function automatic int upd(int prev, int w);
      int d, a, b, r;
      d = (prev ^ w) & 'hFFFF;
      a = d % 16;
      b = ((d / 16) % 16) ^ a;
      r = (prev / 256) ^ (a * 8) ^ (a * 256) ^ b ^ (b * 128) ^ (b * 4096);
      return r & 'hFFFF;
   endfunction

   task automatic push(bit rd, bit wr, int addr, int wdata, bit done);
      step_t e;
      e.bsy = 1'b1; e.rd = rd; e.wr = wr; e.addr = addr % MSZ; e.wdata = wdata; e.done = done;
      q.push_back(e);
   endtask

   // Expected per-cycle port activity for one job (R1 R2 R4 R5 R6 R7 R8 R10)
   task automatic plan(int s, int n, int t);
      int sum, p;
      sum = 'hFFFF;
      p = s;
      for (int k = 0; k < n / 2; k++) begin
         push(1, 0, p, 0, 0);
         push(1, 0, p + 1, 0, 0);
         push(0, 0, 0, 0, 0);
         sum = upd(sum, int'(mem[p % MSZ]) * 256 + int'(mem[(p + 1) % MSZ]));
         p = p + 2;
      end
      if (n % 2 == 1) begin
         push(1, 0, p, 0, 0);
         push(0, 0, 0, 0, 0);
         sum = upd(sum, int'(mem[p % MSZ]) * 256);
      end
      push(0, 1, t, sum / 256, 0);
      push(0, 1, t + 1, sum % 256, 0);
      push(0, 0, 0, 0, 1);
   endtask

   task automatic tick();
      step_t e;
      bit ok;
      string tag;
      @(negedge clk);
      if (q.size() > 0) e = q.pop_front();
      else begin
         e.bsy = 0; e.rd = 0; e.wr = 0; e.addr = 0; e.wdata = 0; e.done = 0;
      end
      ok = (busy_o == e.bsy) && (mem_rd_o == e.rd) && (mem_wr_o == e.wr) && (done_o == e.done);
      if (ok && (e.rd || e.wr)) ok = (int'(mem_addr_o) == e.addr);
      if (ok && e.wr) ok = (int'(mem_wdata_o) == e.wdata);
      tag = e.wr ? "R7/R3" : e.rd ? "R5/R6" : e.done ? "R8" : "R9";
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got busy=%0d rd=%0d wr=%0d addr=%0h wdata=%0h done=%0d, expected busy=%0d rd=%0d wr=%0d addr=%0h wdata=%0h done=%0d",
                  tag, busy_o, mem_rd_o, mem_wr_o, mem_addr_o, mem_wdata_o, done_o,
                  e.bsy, e.rd, e.wr, e.addr, e.wdata, e.done);
      end
   endtask

   task automatic launch(int s, int n, int t);
      start_addr_i = AW'(s);
      count_i = (AW + 1)'(n);
      store_addr_i = AW'(t);
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
   endtask

   task automatic run(int s, int n, int t);
      plan(s, n, t);
      launch(s, n, t);
      while (q.size() > 0) tick();
      tick();
   endtask

   initial begin
      #(20.0 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R9 reset state: idle, no strobes
      tick();
      tick();
      rst_n = 1'b1;
      tick();
      // standard region, even count (R2 R3 R5 R6)
      run('h00, 'hF8, 'hFC);
      // odd count, padded final byte (R4)
      run('h10, 5, 'hE0);
      // single byte (R4)
      run('h33, 1, 'hE2);
      // empty region yields the seed (R1)
      run('h60, 0, 'hE4);
      // one word (R2)
      run('h40, 2, 'hE6);
      // reads wrap past the top of memory (R10)
      run('hFD, 6, 'hE8);
      // store address wraps (R10)
      run('h50, 3, 'hFF);
      // R9: start while busy is ignored, also in the done cycle
      plan('h80, 8, 'hEA);
      launch('h80, 8, 'hEA);
      tick();
      tick();
      start_addr_i = 8'h20; count_i = 9'd3; store_addr_i = 8'h00;
      start_i = 1'b1;
      tick();
      tick();
      start_i = 1'b0;
      while (q.size() > 0) tick();
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
      tick();
      tick();
      // back-to-back job after idle (R8 R9)
      run('h02, 4, 'hEC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule